// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Unit

This block sits between a host bus and the datapath of a network adapter. The host writes 16-bit command words to a single command port. The top five bits of each word select an operation, and the lower eleven bits carry its operand. The block keeps a 3-bit register-window selector, a bank of interrupt cause flags, an interrupt enable mask and a read-visibility mask. A single status word combines the selected window, a busy flag and the visible cause flags.

Receive, transmit and statistics control commands leave the block as one-cycle strobes on a pulse vector. Matching level outputs show whether each function is currently switched on. The datapath reports events through per-cause pulse inputs. The host clears causes with an acknowledge command whose operand is a bit mask. A global reset command keeps the unit busy for a programmable number of cycles. During that time it refuses new commands and ignores new events.

Top module: `wincmd_ctrl`

## Requirements
- R1: After synchronous reset, status_word is 0x0000, irq is 0, cmd_pulse is 0 and rx_on, tx_on and stats_on are 0.
- R2: cmd_data[15:11] is the opcode and cmd_data[10:0] is the operand. Opcode 1 loads the window from operand bits 2..0, and the higher operand bits have no effect. status_word[15:13] shows the new window in the cycle after the write edge.
- R3: The following opcodes raise exactly one cmd_pulse bit for one cycle, in the cycle after the write edge: 4 raises bit 0 and sets rx_on; 3 raises bit 1 and clears rx_on; 5 raises bit 2 and clears rx_on; 9 raises bit 3 and sets tx_on; 10 raises bit 4 and clears tx_on; 11 raises bit 5 and clears tx_on; 21 raises bit 6 and sets stats_on; 22 raises bit 7 and clears stats_on.
- R4: A high evt[k] for k in 1..7 sets cause flag k. evt[0] has no effect. Opcode 12 sets cause flag 6.
- R5: Opcode 13 clears every cause flag k (1..7) whose operand bit k is 1. If a flag is set and cleared in the same cycle, the set wins.
- R6: Opcode 14 loads the interrupt mask from operand bits 7..0. irq is the OR of cause flags 7..1, each ANDed with its mask bit. status_word bit 0 carries irq.
- R7: Opcode 15 loads the read-visibility mask from operand bits 7..0. Status bit k (7..0) reads 0 whenever visibility bit k is 0. The mask changes only what is read and leaves the flags themselves untouched.
- R8: status_word[11:8] always reads 0, and status_word[12] is the busy flag.
- R9: Opcode 0 clears the window, both masks, all cause flags, rx_on, tx_on and stats_on. After it, busy reads 1 for exactly RST_CYCLES cycles. While busy, commands and events are ignored.
- R10: Opcodes without a defined action (2, 6, 7, 8, 16 to 20 and 23 to 31) change no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode and operand |
| evt | input | 8 | Datapath event pulses, one per cause bit (bit 0 unused) |
| status_word | output | 16 | Window, busy flag, zero field, visible causes |
| irq | output | 1 | Interrupt request |
| cmd_pulse | output | 8 | One-cycle command strobes |
| rx_on | output | 1 | Receive enabled |
| tx_on | output | 1 | Transmit enabled |
| stats_on | output | 1 | Statistics enabled |

## Verification
All state shows up at the ports within one cycle. A wrong window, mask or cause flag changes status_word or irq at the very next compare after the faulty edge. A busy counter that is off by one shows as a mismatch in status bit 12 at the end of the reset window. A command that leaks through while busy shows in the compare that follows it. The bench exercises masks with partial patterns and acknowledges that coincide with events, so that crossed bit lanes and a wrong set/clear priority cannot hide.

// File: rtl/wincmd_pkg.sv
package wincmd_pkg;
  localparam int OPW = 5;
  localparam int ARGW = 11;
  localparam int NCAUSE = 8;
  localparam int NPULSE = 8;

  typedef enum logic [OPW-1:0] {
    OP_GRESET  = 5'd0,
    OP_WINDOW  = 5'd1,
    OP_RX_OFF  = 5'd3,
    OP_RX_ON   = 5'd4,
    OP_RX_RST  = 5'd5,
    OP_TX_ON   = 5'd9,
    OP_TX_OFF  = 5'd10,
    OP_TX_RST  = 5'd11,
    OP_REQ     = 5'd12,
    OP_ACK     = 5'd13,
    OP_IMASK   = 5'd14,
    OP_VMASK   = 5'd15,
    OP_ST_ON   = 5'd21,
    OP_ST_OFF  = 5'd22
  } opcode_e;

  localparam int P_RX_ON  = 0;
  localparam int P_RX_OFF = 1;
  localparam int P_RX_RST = 2;
  localparam int P_TX_ON  = 3;
  localparam int P_TX_OFF = 4;
  localparam int P_TX_RST = 5;
  localparam int P_ST_ON  = 6;
  localparam int P_ST_OFF = 7;

  localparam int REQ_BIT = 6;

  typedef struct packed {
    logic              greset;
    logic              win;
    logic              ack;
    logic              req;
    logic              imask;
    logic              vmask;
    logic [NPULSE-1:0] pulse;
  } dec_t;
endpackage

// File: rtl/wincmd_decode.sv
module wincmd_decode
  import wincmd_pkg::*;
(
  input  logic                 wr,
  input  logic                 busy,
  input  logic [OPW-1:0]       op,
  output dec_t                 dec
);
  logic take;
  assign take = wr & ~busy;

  always_comb begin
    dec = '0;
    if (take) begin
      case (op)
        OP_GRESET: dec.greset = 1'b1;
        OP_WINDOW: dec.win    = 1'b1;
        OP_ACK:    dec.ack    = 1'b1;
        OP_REQ:    dec.req    = 1'b1;
        OP_IMASK:  dec.imask  = 1'b1;
        OP_VMASK:  dec.vmask  = 1'b1;
        OP_RX_ON:  dec.pulse[P_RX_ON]  = 1'b1;
        OP_RX_OFF: dec.pulse[P_RX_OFF] = 1'b1;
        OP_RX_RST: dec.pulse[P_RX_RST] = 1'b1;
        OP_TX_ON:  dec.pulse[P_TX_ON]  = 1'b1;
        OP_TX_OFF: dec.pulse[P_TX_OFF] = 1'b1;
        OP_TX_RST: dec.pulse[P_TX_RST] = 1'b1;
        OP_ST_ON:  dec.pulse[P_ST_ON]  = 1'b1;
        OP_ST_OFF: dec.pulse[P_ST_OFF] = 1'b1;
        default:   dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/wincmd_timer.sv
module wincmd_timer #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(RST_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= LOADV;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/wincmd_causes.sv
module wincmd_causes #(
  parameter int NC = 8,
  parameter int REQ_IDX = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic          hold,
  input  logic [NC-1:0] ev,
  input  logic          req,
  input  logic          ack,
  input  logic [NC-1:0] ack_bits,
  output logic [NC-1:0] flags
);
  assign flags[0] = 1'b0;

  for (genvar k = 1; k < NC; k++) begin : g_bit
    logic set_k;
    logic clr_k;
    assign set_k = ev[k] | ((k == REQ_IDX) ? req : 1'b0);
    assign clr_k = ack & ack_bits[k];
    always_ff @(posedge clk) begin
      if (rst || clr_all) flags[k] <= 1'b0;
      else if (hold)      flags[k] <= flags[k];
      else if (set_k)     flags[k] <= 1'b1;
      else if (clr_k)     flags[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/wincmd_ctrl.sv
module wincmd_ctrl
  import wincmd_pkg::*;
#(
  parameter int RST_CYCLES = 8,
  parameter int WINW = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [15:0] cmd_data,
  input  logic [7:0]  evt,
  output logic [15:0] status_word,
  output logic        irq,
  output logic [7:0]  cmd_pulse,
  output logic        rx_on,
  output logic        tx_on,
  output logic        stats_on
);
  localparam int ZW = 16 - WINW - 1 - NCAUSE;

  logic [OPW-1:0]    op;
  logic [ARGW-1:0]   arg;
  logic              busy;
  dec_t              dec;
  logic [WINW-1:0]   win_q;
  logic [NCAUSE-1:0] imask_q, vmask_q, flags, visible;

  assign op  = cmd_data[15:11];
  assign arg = cmd_data[10:0];

  wincmd_decode u_dec (
    .wr(cmd_wr), .busy(busy), .op(op), .dec(dec)
  );

  wincmd_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(dec.greset), .busy(busy)
  );

  wincmd_causes #(.NC(NCAUSE), .REQ_IDX(REQ_BIT)) u_cau (
    .clk(clk), .rst(rst), .clr_all(dec.greset), .hold(busy),
    .ev(evt), .req(dec.req), .ack(dec.ack),
    .ack_bits(arg[NCAUSE-1:0]), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst || dec.greset) begin
      win_q    <= '0;
      imask_q  <= '0;
      vmask_q  <= '0;
      rx_on    <= 1'b0;
      tx_on    <= 1'b0;
      stats_on <= 1'b0;
    end else begin
      if (dec.win)   win_q   <= arg[WINW-1:0];
      if (dec.imask) imask_q <= arg[NCAUSE-1:0];
      if (dec.vmask) vmask_q <= arg[NCAUSE-1:0];
      if (dec.pulse[P_RX_ON])                               rx_on <= 1'b1;
      else if (dec.pulse[P_RX_OFF] || dec.pulse[P_RX_RST])  rx_on <= 1'b0;
      if (dec.pulse[P_TX_ON])                               tx_on <= 1'b1;
      else if (dec.pulse[P_TX_OFF] || dec.pulse[P_TX_RST])  tx_on <= 1'b0;
      if (dec.pulse[P_ST_ON])                               stats_on <= 1'b1;
      else if (dec.pulse[P_ST_OFF])                         stats_on <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_pulse <= '0;
    else     cmd_pulse <= dec.pulse;
  end

  assign irq     = |(flags[NCAUSE-1:1] & imask_q[NCAUSE-1:1]);
  assign visible = {flags[NCAUSE-1:1], irq} & vmask_q;
  assign status_word = {win_q, busy, {ZW{1'b0}}, visible};
endmodule

// File: rtl/wincmd_ctrl_chk.sv
module wincmd_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_wr,
  input logic [15:0] cmd_data,
  input logic [7:0]  evt,
  input logic [15:0] status_word,
  input logic        irq,
  input logic [7:0]  cmd_pulse,
  input logic        rx_on,
  input logic        tx_on,
  input logic        stats_on
);
  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (rst)
    status_word[11:8] == 4'h0);

  assert_pulse_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_pulse));

  assert_pulse_source_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_pulse != 8'h00) |-> ($past(cmd_wr) && !$past(status_word[12])));

  assert_rx_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_on) |-> cmd_pulse[0]);

  assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    status_word[12] |-> (status_word[15:13] == 3'd0 && status_word[7:0] == 8'h00
                         && !irq && !rx_on && !tx_on && !stats_on));

  assert_greset_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_data[15:11] == 5'd0 && !status_word[12]) |=> status_word[12]);

  assert_unknown_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_data[15:11] == 5'd2 && !status_word[12])
      |=> ($stable(status_word[15:13]) && cmd_pulse == 8'h00));
endmodule

bind wincmd_ctrl wincmd_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .evt(evt),
  .status_word(status_word), .irq(irq), .cmd_pulse(cmd_pulse),
  .rx_on(rx_on), .tx_on(tx_on), .stats_on(stats_on)
);

// File: tb/wincmd_ctrl_test.sv
module wincmd_ctrl_test;
  localparam int NRST = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_data = 16'h0;
  logic [7:0]  evt = 8'h0;
  logic [15:0] status_word;
  logic        irq;
  logic [7:0]  cmd_pulse;
  logic        rx_on, tx_on, stats_on;

  int vecs = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  wincmd_ctrl #(.RST_CYCLES(NRST)) uut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .evt(evt),
    .status_word(status_word), .irq(irq), .cmd_pulse(cmd_pulse),
    .rx_on(rx_on), .tx_on(tx_on), .stats_on(stats_on)
  );

  // behavioural reference
  bit [2:0] m_win;
  bit [7:0] m_cause, m_im, m_vm, m_pulse;
  bit       m_rx, m_tx, m_st;
  int       m_cnt;
  bit       started = 1'b0;

  always @(posedge clk) begin
    bit [4:0] op;
    bit [7:0] a8;
    op = cmd_data[15:11];
    a8 = cmd_data[7:0];
    started = 1'b1;
    m_pulse = 8'h00;
    if (rst) begin
      m_win = 0; m_cause = 0; m_im = 0; m_vm = 0;
      m_rx = 0; m_tx = 0; m_st = 0; m_cnt = 0;
    end else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
    end else if (cmd_wr && op == 5'd0) begin
      m_win = 0; m_cause = 0; m_im = 0; m_vm = 0;
      m_rx = 0; m_tx = 0; m_st = 0; m_cnt = NRST;
    end else begin
      if (cmd_wr) begin
        case (op)
          5'd1:  m_win = cmd_data[2:0];
          5'd4:  begin m_pulse = 8'h01; m_rx = 1; end
          5'd3:  begin m_pulse = 8'h02; m_rx = 0; end
          5'd5:  begin m_pulse = 8'h04; m_rx = 0; end
          5'd9:  begin m_pulse = 8'h08; m_tx = 1; end
          5'd10: begin m_pulse = 8'h10; m_tx = 0; end
          5'd11: begin m_pulse = 8'h20; m_tx = 0; end
          5'd21: begin m_pulse = 8'h40; m_st = 1; end
          5'd22: begin m_pulse = 8'h80; m_st = 0; end
          5'd12: m_cause[6] = 1'b1;
          5'd13: m_cause = m_cause & ~a8;
          5'd14: m_im = a8;
          5'd15: m_vm = a8;
          default: ;
        endcase
      end
      m_cause = (m_cause | (evt & 8'hFE)) & 8'hFE;
    end
  end

  function automatic bit m_irq();
    return |(m_cause[7:1] & m_im[7:1]);
  endfunction

  always @(negedge clk) begin
    bit [15:0] exp_s;
    if (started) begin
      exp_s = {m_win, (m_cnt != 0), 4'h0, ({m_cause[7:1], m_irq()} & m_vm)};
      vecs++;
      if (status_word !== exp_s) begin
        bad++;
        $display("FAIL %s status actual=%h expected=%h", cur_req, status_word, exp_s);
      end
      if (irq !== m_irq()) begin
        bad++;
        $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, m_irq());
      end
      if (cmd_pulse !== m_pulse) begin
        bad++;
        $display("FAIL %s pulse actual=%h expected=%h", cur_req, cmd_pulse, m_pulse);
      end
      if ({rx_on, tx_on, stats_on} !== {m_rx, m_tx, m_st}) begin
        bad++;
        $display("FAIL %s levels actual=%b expected=%b", cur_req,
                 {rx_on, tx_on, stats_on}, {m_rx, m_tx, m_st});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  task automatic step(input bit wr, input bit [4:0] op, input bit [10:0] arg,
                      input bit [7:0] ev);
    @(posedge clk); #2;
    cmd_wr = wr; cmd_data = {op, arg}; evt = ev;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 5'd0, 11'h0, 8'h00);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    idle(2);

    cur_req = "R2";
    step(1, 5'd1, 11'h7FD, 8'h00);   // window 5, high operand bits junk
    step(1, 5'd1, 11'h007, 8'h00);
    step(1, 5'd1, 11'h3F8, 8'h00);   // window 0
    step(1, 5'd1, 11'h002, 8'h00);
    idle(1);

    cur_req = "R3";
    step(1, 5'd4, 11'h7FF, 8'h00);
    step(1, 5'd9, 11'h000, 8'h00);
    step(1, 5'd21, 11'h000, 8'h00);
    idle(1);
    step(1, 5'd3, 11'h000, 8'h00);
    step(1, 5'd4, 11'h000, 8'h00);
    step(1, 5'd5, 11'h000, 8'h00);
    step(1, 5'd10, 11'h000, 8'h00);
    step(1, 5'd9, 11'h000, 8'h00);
    step(1, 5'd11, 11'h000, 8'h00);
    step(1, 5'd22, 11'h000, 8'h00);
    idle(1);

    cur_req = "R6";
    step(1, 5'd15, 11'h0FF, 8'h00);
    step(1, 5'd14, 11'h014, 8'h00);   // enable bits 2 and 4

    cur_req = "R4";
    step(0, 5'd0, 11'h0, 8'h01);      // bit 0 event ignored
    step(0, 5'd0, 11'h0, 8'h08);      // bit 3, masked from irq
    step(0, 5'd0, 11'h0, 8'h10);      // bit 4 -> irq
    step(1, 5'd12, 11'h000, 8'h00);   // request sets bit 6
    step(0, 5'd0, 11'h0, 8'hA6);
    idle(1);

    cur_req = "R5";
    step(1, 5'd13, 11'h010, 8'h10);   // set wins over clear
    step(1, 5'd13, 11'h7FF & 11'h014, 8'h00);
    step(1, 5'd13, 11'h0FF, 8'h00);
    idle(1);

    cur_req = "R7";
    step(0, 5'd0, 11'h0, 8'hFE);
    step(1, 5'd15, 11'h055, 8'h00);
    step(1, 5'd14, 11'h0FE, 8'h00);
    step(1, 5'd15, 11'h0AA, 8'h00);
    step(1, 5'd15, 11'h000, 8'h00);
    step(1, 5'd15, 11'h0FF, 8'h00);
    idle(1);

    cur_req = "R10";
    step(1, 5'd1, 11'h003, 8'h00);
    step(1, 5'd4, 11'h000, 8'h00);
    for (int u = 0; u < 32; u++) begin
      if (!(u inside {0, 1, 3, 4, 5, 9, 10, 11, 12, 13, 14, 15, 21, 22}))
        step(1, 5'(u), 11'h7FF, 8'h00);
    end
    idle(1);

    cur_req = "R9";
    step(1, 5'd0, 11'h7FF, 8'hFE);
    step(1, 5'd4, 11'h000, 8'hFE);
    step(1, 5'd1, 11'h006, 8'h40);
    step(1, 5'd12, 11'h000, 8'h00);
    idle(NRST - 3);
    step(1, 5'd1, 11'h004, 8'h02);   // first accepted edge after busy
    step(1, 5'd15, 11'h0FF, 8'h00);
    step(1, 5'd0, 11'h000, 8'h00);
    step(1, 5'd0, 11'h000, 8'h00);   // ignored while busy
    idle(NRST + 2);

    cur_req = "R8";
    step(1, 5'd15, 11'h0FF, 8'hFE);
    step(1, 5'd14, 11'h0FF, 8'h00);
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule